// File: doc/BRIEF.md
# Region-Indexed Switching Pattern Sequencer

This block drives the four switch pairs of a five-level flying-capacitor converter. It works through one output cycle at a time. On the sample tick that opens a cycle it reads three quantized capacitor voltages and compares each with the centre of its allowed control interval. The three comparison bits form a region index, which picks one of eight stored eight-step switching sequences. The block then applies that sequence, one 4-bit switch state per tick, until the cycle ends. The load current plays no part in the choice.

Software or an offline tool fills the sequence table through a valid/ready write port. A write can only be accepted while the sequencer sits between cycles. The block does not trust the table. Every tick, it checks that the next switch state differs from the present one in exactly one switch pair. It also flags voltages that have drifted out of the control box or out of the wider safe box.

Top module: `fc_pattern_sequencer`

## Requirements
- R1: While reset is active, and after it until the first tick, `mode_o` is 0000, `region_o` is 0, and `cyc_start_o`, `flt_illegal_o`, `flt_unsafe_o` and `flt_outreg_o` are all 0.
- R2: Bit j of the region index is 1 when capacitor voltage j is greater than or equal to (lo_j+hi_j)>>1, and 0 otherwise. Capacitor j occupies bits [j*VW +: VW] of the voltage and bound buses. The index is captured only on a cycle-opening tick and holds for the rest of the cycle, whatever the voltage inputs do.
- R3: A cycle has 8 ticks. The k-th tick of a cycle (k = 0..7) puts step k of the table entry for the captured region on `mode_o`, starting in the clock after the tick. A tick opens a cycle when it is the first tick after reset, or when step 7 is already being shown.
- R4: `cyc_start_o` is high for exactly one clock, the clock following a cycle-opening tick.
- R5: `tbl_ready` is high only when the sequencer is idle and `tick` is low. The sequencer is idle before the first tick and while step 7 is being shown. A word is stored only when `tbl_valid` and `tbl_ready` are both high. It goes to entry `tbl_region`, step `tbl_step`. An offered word with `tbl_ready` low is dropped and does not change the table.
- R6: On every tick except the first one after reset, the block checks the next state against `mode_o`. If they differ in a number of bits other than one, `flt_illegal_o` rises and stays high until reset, and `mode_o` keeps its previous value. The step count still advances.
- R7: `flt_outreg_o` is updated on each cycle-opening tick. It goes to 1 if any voltage is below lo or above hi, and to 0 otherwise. An out-of-box voltage still selects the nearest sub-box through the rule in R2.
- R8: On a cycle-opening tick, `flt_unsafe_o` rises if any voltage v satisfies v+margin < lo or v > hi+margin. It then stays high until reset.
- R9: `mode_o` changes only in the clock after a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Sampling tick, one clock wide |
| v_cap | input | 3*VW | Quantized capacitor voltages, capacitor j in bits [j*VW +: VW] |
| ctl_lo | input | 3*VW | Lower bounds of the control box |
| ctl_hi | input | 3*VW | Upper bounds of the control box |
| safe_margin | input | VW | Widening of the control box that gives the safe box |
| tbl_valid | input | 1 | A table word is offered |
| tbl_ready | output | 1 | The table accepts a word this clock |
| tbl_region | input | 3 | Table entry (region index) to write |
| tbl_step | input | 3 | Step within the entry to write |
| tbl_mode | input | 4 | Switch state to store |
| mode_o | output | 4 | Applied switch state, 1 = high-side switch conducts |
| region_o | output | 3 | Region index captured for the current cycle |
| cyc_start_o | output | 1 | One-clock strobe after a cycle-opening tick |
| flt_illegal_o | output | 1 | Sticky flag: a multi-pair or null transition was refused |
| flt_unsafe_o | output | 1 | Sticky flag: a voltage was outside the safe box |
| flt_outreg_o | output | 1 | A voltage was outside the control box at the last cycle opening |

## Verification
The assertions assume that `tick` is never high on two clocks in a row. The bench always puts at least one quiet clock between ticks. They also assume that each lo is no greater than its hi and that the bound sums fit in VW+1 bits. The bench uses one fixed box whose centres are well inside the voltage range. The table-port back-pressure rule relies on a writer that holds `tbl_valid` and its word until it sees `tbl_ready`. The bench offers writes both at idle clocks and through a whole busy cycle, so that both acceptance and dropping are exercised.

// File: rtl/fc_seq_pkg.sv
package fc_seq_pkg;

  // number of set bits in a word of up to 16 bits
  function automatic int unsigned ones16(input logic [15:0] x);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 16; i++) n += int'(x[i]);
    return n;
  endfunction

endpackage

// File: rtl/fc_region_classifier.sv
module fc_region_classifier #(
  parameter int NCAP = 3,
  parameter int VW   = 10
) (
  input  logic [NCAP*VW-1:0] v_cap,
  input  logic [NCAP*VW-1:0] ctl_lo,
  input  logic [NCAP*VW-1:0] ctl_hi,
  input  logic [VW-1:0]      safe_margin,
  output logic [NCAP-1:0]    region_idx,
  output logic               out_ctl,
  output logic               out_safe
);

  logic [NCAP-1:0] beyond_ctl;
  logic [NCAP-1:0] beyond_safe;

  for (genvar j = 0; j < NCAP; j++) begin : g_cap
    logic [VW:0] v_e, lo_e, hi_e, mg_e, mid_sum;
    assign v_e     = {1'b0, v_cap [j*VW +: VW]};
    assign lo_e    = {1'b0, ctl_lo[j*VW +: VW]};
    assign hi_e    = {1'b0, ctl_hi[j*VW +: VW]};
    assign mg_e    = {1'b0, safe_margin};
    assign mid_sum = lo_e + hi_e;
    // bisection of the interval: upper half includes the midpoint
    assign region_idx[j]  = v_e >= (mid_sum >> 1);
    assign beyond_ctl[j]  = (v_e < lo_e) || (v_e > hi_e);
    assign beyond_safe[j] = ((v_e + mg_e) < lo_e) || (v_e > (hi_e + mg_e));
  end

  assign out_ctl  = |beyond_ctl;
  assign out_safe = |beyond_safe;

endmodule

// File: rtl/fc_pattern_store.sv
module fc_pattern_store #(
  parameter int NCELL = 4,
  parameter int RW    = 3,
  parameter int SW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [RW-1:0]    wr_region,
  input  logic [SW-1:0]    wr_step,
  input  logic [NCELL-1:0] wr_mode,
  input  logic [RW-1:0]    rd_region,
  input  logic [SW-1:0]    rd_step,
  output logic [NCELL-1:0] rd_mode
);

  localparam int AW    = RW + SW;
  localparam int DEPTH = 1 << AW;

  logic [NCELL-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[{wr_region, wr_step}] <= wr_mode;
    end
  end

  assign rd_mode = mem[{rd_region, rd_step}];

endmodule

// File: rtl/fc_step_sequencer.sv
module fc_step_sequencer #(
  parameter int STEPS = 8,
  parameter int SW    = $clog2(STEPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  output logic [SW-1:0] step_q,
  output logic [SW-1:0] next_step,
  output logic          started_q,
  output logic          idle,
  output logic          load_start,
  output logic          cyc_start_q
);

  localparam logic [SW-1:0] LAST = SW'(STEPS - 1);

  assign idle       = !started_q || (step_q == LAST);
  assign load_start = tick && idle;
  assign next_step  = load_start ? '0 : step_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q      <= '0;
      started_q   <= 1'b0;
      cyc_start_q <= 1'b0;
    end else begin
      cyc_start_q <= load_start;
      if (tick) begin
        step_q    <= next_step;
        started_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/fc_transition_guard.sv
module fc_transition_guard #(
  parameter int NCELL = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             check_en,
  input  logic [NCELL-1:0] cand,
  output logic [NCELL-1:0] mode_q,
  output logic             illegal_q
);

  logic [15:0] diff;
  logic        refuse;

  always_comb begin
    diff              = '0;
    diff[NCELL-1:0]   = cand ^ mode_q;
    refuse            = check_en && (fc_seq_pkg::ones16(diff) != 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= '0;
      illegal_q <= 1'b0;
    end else if (tick) begin
      if (refuse) illegal_q <= 1'b1;
      else        mode_q    <= cand;
    end
  end

endmodule

// File: rtl/fc_pattern_sequencer.sv
module fc_pattern_sequencer #(
  parameter int NCELL = 4,
  parameter int VW    = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic [(NCELL-1)*VW-1:0]  v_cap,
  input  logic [(NCELL-1)*VW-1:0]  ctl_lo,
  input  logic [(NCELL-1)*VW-1:0]  ctl_hi,
  input  logic [VW-1:0]            safe_margin,
  input  logic                     tbl_valid,
  output logic                     tbl_ready,
  input  logic [NCELL-2:0]         tbl_region,
  input  logic [$clog2(2*NCELL)-1:0] tbl_step,
  input  logic [NCELL-1:0]         tbl_mode,
  output logic [NCELL-1:0]         mode_o,
  output logic [NCELL-2:0]         region_o,
  output logic                     cyc_start_o,
  output logic                     flt_illegal_o,
  output logic                     flt_unsafe_o,
  output logic                     flt_outreg_o
);

  localparam int NCAP  = NCELL - 1;
  localparam int STEPS = 2 * NCELL;
  localparam int SW    = $clog2(STEPS);
  localparam int RW    = NCAP;

  logic [RW-1:0]    region_now, region_q, rd_region;
  logic             out_ctl_now, out_safe_now;
  logic             outreg_q, unsafe_q;
  logic [SW-1:0]    step_q, next_step;
  logic             started_q, idle, load_start, cyc_start_q;
  logic [NCELL-1:0] cand;

  fc_region_classifier #(.NCAP(NCAP), .VW(VW)) u_class (
    .v_cap       (v_cap),
    .ctl_lo      (ctl_lo),
    .ctl_hi      (ctl_hi),
    .safe_margin (safe_margin),
    .region_idx  (region_now),
    .out_ctl     (out_ctl_now),
    .out_safe    (out_safe_now)
  );

  fc_step_sequencer #(.STEPS(STEPS), .SW(SW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .step_q      (step_q),
    .next_step   (next_step),
    .started_q   (started_q),
    .idle        (idle),
    .load_start  (load_start),
    .cyc_start_q (cyc_start_q)
  );

  // table accepts words only between cycles and never on a tick
  assign tbl_ready = idle && !tick;
  assign rd_region = load_start ? region_now : region_q;

  fc_pattern_store #(.NCELL(NCELL), .RW(RW), .SW(SW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (tbl_valid && tbl_ready),
    .wr_region (tbl_region),
    .wr_step   (tbl_step),
    .wr_mode   (tbl_mode),
    .rd_region (rd_region),
    .rd_step   (next_step),
    .rd_mode   (cand)
  );

  fc_transition_guard #(.NCELL(NCELL)) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .check_en  (started_q),
    .cand      (cand),
    .mode_q    (mode_o),
    .illegal_q (flt_illegal_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      region_q <= '0;
      outreg_q <= 1'b0;
      unsafe_q <= 1'b0;
    end else if (load_start) begin
      region_q <= region_now;
      outreg_q <= out_ctl_now;
      if (out_safe_now) unsafe_q <= 1'b1;
    end
  end

  assign region_o     = region_q;
  assign cyc_start_o  = cyc_start_q;
  assign flt_outreg_o = outreg_q;
  assign flt_unsafe_o = unsafe_q;

endmodule

// File: rtl/fc_pattern_sequencer_chk.sv
module fc_pattern_sequencer_chk #(
  parameter int NCELL = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             tbl_ready,
  input logic [NCELL-1:0] mode_o,
  input logic [NCELL-2:0] region_o,
  input logic             cyc_start_o,
  input logic             flt_illegal_o,
  input logic             flt_unsafe_o
);

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start_o |=> !cyc_start_o);

  assert_mode_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(mode_o));

  assert_one_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ($countones(mode_o ^ $past(mode_o)) <= 1));

  assert_illegal_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flt_illegal_o |=> flt_illegal_o);

  assert_unsafe_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flt_unsafe_o |=> flt_unsafe_o);

  assert_region_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (region_o != $past(region_o)) |-> cyc_start_o);

  assert_ready_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_ready |-> !tick);

endmodule

bind fc_pattern_sequencer fc_pattern_sequencer_chk #(.NCELL(NCELL)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tick          (tick),
  .tbl_ready     (tbl_ready),
  .mode_o        (mode_o),
  .region_o      (region_o),
  .cyc_start_o   (cyc_start_o),
  .flt_illegal_o (flt_illegal_o),
  .flt_unsafe_o  (flt_unsafe_o)
);

// File: tb/fc_pattern_sequencer_tb.sv
module fc_pattern_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic [3*VW-1:0] v_cap = '0, ctl_lo, ctl_hi;
  logic [VW-1:0] safe_margin;
  logic          tbl_valid = 1'b0, tbl_ready;
  logic [2:0]    tbl_region = '0, tbl_step = '0;
  logic [3:0]    tbl_mode = '0;
  logic [3:0]    mode_o;
  logic [2:0]    region_o;
  logic          cyc_start_o, flt_illegal_o, flt_unsafe_o, flt_outreg_o;

  int total = 0, bad = 0;
  bit done = 0;

  int lo_v[3] = '{40, 90, 140};
  int hi_v[3] = '{60, 110, 160};
  int margin_v = 10;

  // reference model state
  int   m_tbl[8][8];
  logic [3:0] m_mode;
  int   m_step, m_region;
  bit   m_started, m_cs, m_ill, m_uns, m_out, m_tick_seen;

  always #(CLK_PERIOD/2) clk = ~clk;

  fc_pattern_sequencer #(.NCELL(4), .VW(VW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .v_cap(v_cap), .ctl_lo(ctl_lo),
    .ctl_hi(ctl_hi), .safe_margin(safe_margin), .tbl_valid(tbl_valid),
    .tbl_ready(tbl_ready), .tbl_region(tbl_region), .tbl_step(tbl_step),
    .tbl_mode(tbl_mode), .mode_o(mode_o), .region_o(region_o),
    .cyc_start_o(cyc_start_o), .flt_illegal_o(flt_illegal_o),
    .flt_unsafe_o(flt_unsafe_o), .flt_outreg_o(flt_outreg_o)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int vol(int j);
    return int'(v_cap[j*VW +: VW]);
  endfunction

  // legal staircase: rise through a rotation of the cells, fall through another
  function automatic int legal_step(int r, int k);
    int m;
    if (k == 0) return 0;
    m = 0;
    if (k <= 4) begin
      for (int i = 0; i < k; i++) m |= 1 << ((r + i) % 4);
    end else begin
      m = 15;
      for (int i = 0; i < k - 4; i++) m &= ~(1 << ((3*r + i) % 4));
    end
    return m;
  endfunction

  task automatic model_edge();
    bit idle;
    int r, nxt;
    logic [3:0] cand;
    idle = !m_started || (m_step == 7);
    if (tbl_valid && idle && !tick) m_tbl[tbl_region][tbl_step] = int'(tbl_mode);
    m_cs = 0;
    m_tick_seen = tick;
    if (tick) begin
      if (idle) begin
        r = 0; m_out = 0;
        for (int j = 0; j < 3; j++) begin
          if (vol(j) >= (lo_v[j] + hi_v[j]) / 2) r |= 1 << j;
          if (vol(j) < lo_v[j] || vol(j) > hi_v[j]) m_out = 1;
          if (vol(j) + margin_v < lo_v[j] || vol(j) > hi_v[j] + margin_v) m_uns = 1;
        end
        m_region = r; m_cs = 1; nxt = 0;
      end else begin
        nxt = m_step + 1;
      end
      cand = 4'(m_tbl[m_region][nxt]);
      if (m_started && $countones(cand ^ m_mode) != 1) m_ill = 1;
      else m_mode = cand;
      m_step = nxt; m_started = 1;
    end
  endtask

  task automatic compare_all();
    bit idle;
    idle = !m_started || (m_step == 7);
    chk(m_tick_seen ? "R3 mode" : "R9 mode", int'(mode_o), int'(m_mode));
    chk("R2 region", int'(region_o), m_region);
    chk("R4 strobe", int'(cyc_start_o), int'(m_cs));
    chk("R6 illegal", int'(flt_illegal_o), int'(m_ill));
    chk("R7 outreg", int'(flt_outreg_o), int'(m_out));
    chk("R8 unsafe", int'(flt_unsafe_o), int'(m_uns));
    chk("R5 ready", int'(tbl_ready), int'(idle && !tick));
  endtask

  task automatic clk_step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic set_v(int a, int b, int c);
    v_cap = {VW'(c), VW'(b), VW'(a)};
  endtask

  // one cycle of 8 ticks with a quiet clock after each; optional mid-cycle
  // voltage change and an offered write held through the busy part
  task automatic run_cycle(int a, int b, int c, bit scramble, bit busy_wr);
    set_v(a, b, c);
    for (int i = 0; i < 8; i++) begin
      tick = 1'b1;
      clk_step();
      tick = 1'b0;
      if (scramble && i == 2) set_v(1000 - a, 0, 1000 - c);
      if (busy_wr && i < 7) begin
        tbl_valid = 1'b1; tbl_region = 3'd5; tbl_step = 3'd2; tbl_mode = 4'hF;
      end else begin
        tbl_valid = 1'b0;
      end
      clk_step();
    end
    tbl_valid = 1'b0;
  endtask

  initial begin
    ctl_lo = {VW'(lo_v[2]), VW'(lo_v[1]), VW'(lo_v[0])};
    ctl_hi = {VW'(hi_v[2]), VW'(hi_v[1]), VW'(hi_v[0])};
    safe_margin = VW'(margin_v);
    for (int r = 0; r < 8; r++) for (int k = 0; k < 8; k++) m_tbl[r][k] = 0;
    m_mode = '0; m_step = 0; m_region = 0; m_started = 0;
    m_cs = 0; m_ill = 0; m_uns = 0; m_out = 0; m_tick_seen = 0;

    repeat (3) @(negedge clk);
    // R1: outputs under reset
    chk("R1 mode", int'(mode_o), 0);
    chk("R1 region", int'(region_o), 0);
    chk("R1 flags", int'({cyc_start_o, flt_illegal_o, flt_unsafe_o, flt_outreg_o}), 0);
    rst_n = 1'b1;
    repeat (2) clk_step();
    chk("R1 mode idle", int'(mode_o), 0);

    // R5: load all entries at idle
    for (int r = 0; r < 8; r++) begin
      for (int k = 0; k < 8; k++) begin
        tbl_valid = 1'b1; tbl_region = 3'(r); tbl_step = 3'(k);
        tbl_mode = 4'(legal_step(r, k));
        clk_step();
      end
    end
    tbl_valid = 1'b0;
    clk_step();

    // R2/R3: region patterns, midpoint boundary, below midpoint
    run_cycle(50, 100, 150, 0, 0);   // region 7, at midpoints
    run_cycle(49, 99, 149, 0, 0);    // region 0
    run_cycle(55, 90, 145, 0, 0);    // region 1
    run_cycle(45, 105, 155, 0, 0);   // region 6
    run_cycle(41, 109, 141, 1, 0);   // region 2, inputs move mid-cycle
    // R7: outside control box, inside safe box, then back inside
    run_cycle(35, 100, 150, 0, 0);
    chk("R7 nearest box", int'(region_o), 6);
    run_cycle(45, 100, 150, 0, 0);
    // R5: write offered during a busy cycle is dropped
    run_cycle(55, 90, 155, 0, 1);    // region 5
    run_cycle(55, 90, 155, 0, 0);
    // R6: store an illegal step at idle, then play it
    tbl_valid = 1'b1; tbl_region = 3'd6; tbl_step = 3'd3; tbl_mode = 4'h0;
    clk_step();
    tbl_valid = 1'b0;
    run_cycle(45, 105, 155, 0, 0);
    chk("R6 sticky", int'(flt_illegal_o), 1);
    // R8: unsafe voltage, stays flagged on a later good cycle
    run_cycle(175, 100, 150, 0, 0);
    run_cycle(50, 100, 150, 0, 0);
    chk("R8 sticky", int'(flt_unsafe_o), 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule